// File: doc/BRIEF.md
# Four-Level Backplane Bus Arbiter

This block is the central arbiter used by the board that acts as system controller on a backplane with four bus request levels. Each cycle it looks at the four active-low request lines and the active-low bus-busy line. When the bus is free, it picks one requesting level and drives that level's active-low grant into the daisy chain. A software-visible mode input chooses how the winner is picked: only the top level is served, fixed priority, or rotating (round-robin) order.

Once a requester takes the bus by asserting bus-busy, the grant is dropped. A new arbitration starts only after bus-busy is released. In fixed-priority mode the arbiter asks the current owner to leave by asserting bus-clear whenever a higher level is waiting. A programmable timer withdraws a grant that no board picks up within the set number of clocks, and reports the event with a one-clock timeout pulse. A strap input, sampled while reset is held, decides whether the arbiter is active at all. A low strap makes it active.

Top module: `busArbiter`

## Requirements
- R1: While reset is low, `sysCtlStrapN` is captured. If it was high, the arbiter stays inert until the next reset: all grants and bus-clear stay high and no timeout pulse occurs, whatever the requests.
- R2: Right after reset, `busGrantN` is all ones, `busClearN` is 1 and `arbTimeout` is 0.
- R3: At most one bit of `busGrantN` is low at any time. Bit i is the grant for level i.
- R4: A grant is issued only from idle, and only when `busBusyN` is high and an eligible request is present at a rising edge. The grant line goes low right after that edge. While `busBusyN` is held low, no new grant is issued.
- R5: While a grant is out, a low `busBusyN` at a rising edge removes the grant right after that edge. The owner keeps the bus until `busBusyN` returns high.
- R6: With `modeSel` = 01, or the spare code 11, the highest requesting level wins. Level 3 is the highest and level 0 the lowest.
- R7: With `modeSel` = 10 (round-robin), the search starts one level below the last level granted, counts downward and wraps from 0 to 3. After reset the search starts at level 3.
- R8: With `modeSel` = 00 (single-level), only level 3 requests are granted. Requests on levels 0 to 2 are ignored.
- R9: In mode 01, `busClearN` is low exactly while the bus is owned and some request is pending at a level above the owner's. In every other mode `busClearN` stays high.
- R10: If `busBusyN` stays high for `grantTimeout` clocks after a grant appears, the grant is withdrawn and `arbTimeout` is high for exactly one clock. A limit of 0 acts as 1. A request that is still pending is granted again on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rstN | input | 1 | Synchronous active-low reset |
| sysCtlStrapN | input | 1 | Strap sampled during reset; low enables the arbiter |
| modeSel | input | 2 | 00 single-level, 01 priority, 10 round-robin, 11 priority |
| grantTimeout | input | TIMER_W (8) | Clocks a grant may wait for bus-busy |
| busReqN | input | NUM_LVL (4) | Active-low request per level |
| busBusyN | input | 1 | Active-low bus-busy |
| busGrantN | output | NUM_LVL (4) | Active-low grant per level, into the daisy chain |
| busClearN | output | 1 | Active-low request for the owner to release the bus |
| arbTimeout | output | 1 | One-clock pulse when a grant is withdrawn unclaimed |

## Verification
Internal state shows up on the grant lines quickly. A wrong phase of the controller appears as a grant issued while busy is held, or as a grant that survives a busy edge, and either is visible one clock later. A corrupted round-robin pointer or winner select does not show on the first grant. It shows on the next arbitration, so the directed sequences run several rounds back to back. A miscounting timer moves the withdrawal clock and the timeout pulse by whole cycles, so those are checked on exact clocks.

// File: rtl/arbPkg.sv
package arbPkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_PRIO   = 2'b01,
    MODE_RR     = 2'b10,
    MODE_SPARE  = 2'b11
  } arbMode_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadGrant;
    logic cntEn;
    logic grantOn;
    logic busyOn;
  } arbStrobe_t;
endpackage

// File: rtl/arbData.sv
module arbData
  import arbPkg::*;
#(
  parameter int NUM_LVL = 4,
  parameter int TIMER_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  arbMode_e           mode,
  input  logic [TIMER_W-1:0] limit,
  input  logic [NUM_LVL-1:0] reqActive,
  input  arbStrobe_t         strobe,
  output logic               winnerValid,
  output logic               timerDone,
  output logic [NUM_LVL-1:0] grantN,
  output logic               clearN
);
  localparam int LVL_W = $clog2(NUM_LVL);

  logic [LVL_W-1:0]   winnerLvl;
  logic [LVL_W-1:0]   grantLvl;
  logic [LVL_W-1:0]   rrPtr;
  logic [TIMER_W-1:0] cnt;
  logic               higherPending;

  // winner select per mode
  always_comb begin
    int idx;
    winnerValid = 1'b0;
    winnerLvl   = '0;
    idx         = 0;
    case (mode)
      MODE_SINGLE: begin
        if (reqActive[NUM_LVL-1]) begin
          winnerValid = 1'b1;
          winnerLvl   = LVL_W'(NUM_LVL - 1);
        end
      end
      MODE_RR: begin
        // last overwrite is the level just below the pointer
        for (int i = NUM_LVL; i >= 1; i--) begin
          idx = (int'(rrPtr) + NUM_LVL - i) % NUM_LVL;
          if (reqActive[idx]) begin
            winnerValid = 1'b1;
            winnerLvl   = LVL_W'(idx);
          end
        end
      end
      default: begin
        for (int i = 0; i < NUM_LVL; i++) begin
          if (reqActive[i]) begin
            winnerValid = 1'b1;
            winnerLvl   = LVL_W'(i);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantLvl <= '0;
      rrPtr    <= '0;
      cnt      <= '0;
    end else if (strobe.loadGrant) begin
      grantLvl <= winnerLvl;
      rrPtr    <= winnerLvl;
      cnt      <= '0;
    end else if (strobe.cntEn) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign timerDone = ({1'b0, cnt} + 1'b1) >= {1'b0, limit};

  always_comb begin
    higherPending = 1'b0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (reqActive[i] && (LVL_W'(i) > grantLvl)) higherPending = 1'b1;
    end
  end

  assign grantN = strobe.grantOn ? ~(NUM_LVL'(1) << grantLvl) : '1;
  assign clearN = ~(strobe.busyOn && (mode == MODE_PRIO) && higherPending);

  a_r3_one_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~grantN));

  a_r9_clear_prio_only: assert property (@(posedge clk) disable iff (!rstN)
    !clearN |-> (mode == MODE_PRIO));

  a_r8_single_top_only: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.grantOn && !$past(strobe.grantOn) && $past(mode) == MODE_SINGLE)
      |-> !grantN[NUM_LVL-1]);
endmodule

// File: rtl/arbCtrl.sv
module arbCtrl
  import arbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       strapN,
  input  logic       busyN,
  input  logic       winnerValid,
  input  logic       timerDone,
  output arbStrobe_t strobe,
  output logic       timeoutPulse
);
  typedef enum logic [1:0] {ST_IDLE, ST_GRANT, ST_BUSY} arbState_e;

  arbState_e state;
  logic      sysEn;

  always_comb begin
    strobe.loadGrant = (state == ST_IDLE) && sysEn && busyN && winnerValid;
    strobe.cntEn     = (state == ST_GRANT) && busyN && !timerDone;
    strobe.grantOn   = (state == ST_GRANT);
    strobe.busyOn    = (state == ST_BUSY);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      timeoutPulse <= 1'b0;
      sysEn        <= ~strapN;
    end else begin
      timeoutPulse <= 1'b0;
      case (state)
        ST_IDLE:  if (strobe.loadGrant) state <= ST_GRANT;
        ST_GRANT: begin
          if (!busyN) state <= ST_BUSY;
          else if (timerDone) begin
            state        <= ST_IDLE;
            timeoutPulse <= 1'b1;
          end
        end
        ST_BUSY:  if (busyN) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  a_r4_grant_after_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.grantOn) |-> $past(busyN));

  a_r5_drop_on_busy: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.grantOn && !busyN) |=> !strobe.grantOn);

  a_r10_pulse_after_grant: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> $past(state == ST_GRANT));

  a_r1_inert_when_strapped: assert property (@(posedge clk) disable iff (!rstN)
    !sysEn |-> (!strobe.grantOn && !timeoutPulse));
endmodule

// File: rtl/busArbiter.sv
module busArbiter
  import arbPkg::*;
#(
  parameter int NUM_LVL = 4,
  parameter int TIMER_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sysCtlStrapN,
  input  logic [1:0]         modeSel,
  input  logic [TIMER_W-1:0] grantTimeout,
  input  logic [NUM_LVL-1:0] busReqN,
  input  logic               busBusyN,
  output logic [NUM_LVL-1:0] busGrantN,
  output logic               busClearN,
  output logic               arbTimeout
);
  arbStrobe_t strobe;
  logic       winnerValid;
  logic       timerDone;

  arbCtrl ctrl (
    .clk(clk), .rstN(rstN), .strapN(sysCtlStrapN), .busyN(busBusyN),
    .winnerValid(winnerValid), .timerDone(timerDone),
    .strobe(strobe), .timeoutPulse(arbTimeout)
  );

  arbData #(.NUM_LVL(NUM_LVL), .TIMER_W(TIMER_W)) data (
    .clk(clk), .rstN(rstN), .mode(arbMode_e'(modeSel)), .limit(grantTimeout),
    .reqActive(~busReqN), .strobe(strobe), .winnerValid(winnerValid),
    .timerDone(timerDone), .grantN(busGrantN), .clearN(busClearN)
  );
endmodule

// File: tb/busArbiter_test.sv
module busArbiter_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       strapN = 1'b0;
  logic [1:0] modeSel = 2'b01;
  logic [7:0] limit = 8'd20;
  logic [3:0] reqN = 4'hF;
  logic       busyN = 1'b1;
  logic [3:0] grantN;
  logic       clearN;
  logic       tmo;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  busArbiter uut (
    .clk(clk), .rstN(rstN), .sysCtlStrapN(strapN), .modeSel(modeSel),
    .grantTimeout(limit), .busReqN(reqN), .busBusyN(busyN),
    .busGrantN(grantN), .busClearN(clearN), .arbTimeout(tmo)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic strap);
    rstN = 1'b0; strapN = strap; reqN = 4'hF; busyN = 1'b1;
    repeat (3) step();
    rstN = 1'b1; strapN = 1'b0;
    step();
  endtask

  // grant visible; take bus, release, next grant visible
  task automatic serve(input string tag, input logic [3:0] expGrant);
    chk(tag, {4'h0, grantN}, {4'h0, expGrant});
    busyN = 1'b0; step();
    busyN = 1'b1; step();
    step();
  endtask

  task automatic testReset();
    doReset(1'b0);
    chk("R2 grants", {4'h0, grantN}, 8'h0F);
    chk("R2 clear", {7'h0, clearN}, 8'h1);
    chk("R2 timeout", {7'h0, tmo}, 8'h0);
  endtask

  task automatic testPriority();
    doReset(1'b0);
    modeSel = 2'b01; reqN = 4'b0000; step();
    chk("R6 top level wins", {4'h0, grantN}, 8'h07);
    busyN = 1'b0; step();
    chk("R5 grant dropped", {4'h0, grantN}, 8'h0F);
    chk("R9 no clear above top", {7'h0, clearN}, 8'h1);
    busyN = 1'b1; reqN = 4'b1101; step();
    step();
    chk("R6 lone level 1", {4'h0, grantN}, 8'h0D);
    busyN = 1'b0; step();
    reqN = 4'b1110; step();
    chk("R9 lower pending no clear", {7'h0, clearN}, 8'h1);
    reqN = 4'b0111; step();
    chk("R9 higher pending clear", {7'h0, clearN}, 8'h0);
    chk("R4 no grant while busy", {4'h0, grantN}, 8'h0F);
    step();
    chk("R4 still no grant", {4'h0, grantN}, 8'h0F);
    busyN = 1'b1; step();
    chk("R5 owner released", {4'h0, grantN}, 8'h0F);
    step();
    chk("R4 grant after release", {4'h0, grantN}, 8'h07);
    busyN = 1'b0; reqN = 4'hF; step();
    busyN = 1'b1; step();
    modeSel = 2'b11; reqN = 4'b1100; step();
    chk("R6 spare code as priority", {4'h0, grantN}, 8'h0D);
    busyN = 1'b0; reqN = 4'hF; step();
    busyN = 1'b1; step();
  endtask

  task automatic testRoundRobin();
    doReset(1'b0);
    modeSel = 2'b10; reqN = 4'b0000; step();
    serve("R7 first level3", 4'b0111);
    serve("R7 then level2", 4'b1011);
    serve("R7 then level1", 4'b1101);
    serve("R7 then level0", 4'b1110);
    reqN = 4'b1010;
    serve("R7 wrap to level3", 4'b0111);
    serve("R7 sparse level2", 4'b1011);
    serve("R7 sparse level0", 4'b1110);
    chk("R7 sparse wrap level2", {4'h0, grantN}, 8'h0B);
    chk("R9 no clear in rr", {7'h0, clearN}, 8'h1);
    busyN = 1'b0; reqN = 4'hF; step();
    busyN = 1'b1; step();
  endtask

  task automatic testSingle();
    doReset(1'b0);
    modeSel = 2'b00; reqN = 4'b1000;
    repeat (3) step();
    chk("R8 low levels ignored", {4'h0, grantN}, 8'h0F);
    reqN = 4'b0000; step();
    chk("R8 level3 served", {4'h0, grantN}, 8'h07);
    busyN = 1'b0; reqN = 4'hF; step();
    busyN = 1'b1; step();
  endtask

  task automatic testTimeout();
    doReset(1'b0);
    modeSel = 2'b01; limit = 8'd4; reqN = 4'b1011; step();
    for (int i = 0; i < 4; i++) begin
      chk("R10 grant held", {4'h0, grantN}, 8'h0B);
      chk("R10 no early pulse", {7'h0, tmo}, 8'h0);
      step();
    end
    chk("R10 grant withdrawn", {4'h0, grantN}, 8'h0F);
    chk("R10 pulse", {7'h0, tmo}, 8'h1);
    step();
    chk("R10 pulse one clock", {7'h0, tmo}, 8'h0);
    chk("R10 regrant", {4'h0, grantN}, 8'h0B);
    limit = 8'd0; step();
    chk("R10 zero limit acts as one", {7'h0, tmo}, 8'h1);
    busyN = 1'b0; reqN = 4'hF; limit = 8'd20; step();
    busyN = 1'b1; step();
  endtask

  task automatic testStrap();
    doReset(1'b1);
    modeSel = 2'b01; reqN = 4'b0000; limit = 8'd1;
    repeat (5) begin
      step();
      chk("R1 inert grant", {4'h0, grantN}, 8'h0F);
      chk("R1 inert timeout", {7'h0, tmo}, 8'h0);
    end
    reqN = 4'hF; limit = 8'd20;
    doReset(1'b0);
    reqN = 4'b1110; step();
    chk("R1 enabled after low strap", {4'h0, grantN}, 8'h0E);
  endtask

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testPriority();
    testRoundRobin();
    testSingle();
    testTimeout();
    testStrap();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule